// File: doc/BRIEF.md
# Bus-Transfer Link Serializer

This block sits behind one or two bus slave ports and carries each single bus transfer across a narrow chip-to-chip link. When an address phase is taken, the port drives its ready output low, captures the write data in the following cycle and shifts an 80-bit request frame out over the link lines, two bits per line per clock. It then waits for the peer's response frame, shifts it in, and ends the transfer with one ready-high cycle that carries the read data and the error flag.

The link has ten lines, seen here as a 20-bit beat bus in each direction plus one frame-marker bit per port. A configuration input sampled during reset picks the partition. In single configuration one port owns all ten lines and a frame takes four beats. In dual configuration each of the two ports owns five lines, a frame takes eight beats, and both ports may have transfers in flight at the same time.

Top module: `ahb_link_ser`

## Requirements
- R1: While reset is held and just after it, both ports show ready high and error low, and both frame markers are low.
- R2: `cfg_dual` is sampled on every clock while reset is low (0 = single, 1 = dual). Changes after reset release do not alter the partition or the beat count.
- R3: A request frame is 80 bits sent least-significant beat first. Bits 31:0 hold the address, 63:32 the write data, 64 the write flag, 67:65 the size, and 79:68 are zero. Beat k carries frame bits [k*W +: W] on the port's lines, and line i carries beat bits 2i and 2i+1.
- R4: In single configuration port A uses all 20 beat bits (W = 20). Its frames take 4 consecutive beats, each marked by `tx_vld[0]`.
- R5: In dual configuration port A uses beat bits 9:0 and port B uses bits 19:10 (W = 10) in both directions. Frames take 8 consecutive beats, marked by `tx_vld[0]` and `tx_vld[1]`.
- R6: Once a valid address phase is taken (`hsel` high, `htrans` 2'b10 or 2'b11, ready high), ready goes low from the next cycle. It stays low through the data-capture cycle, all request beats, the wait for the response and every response beat. If the first response beat comes g cycles after the last request beat, ready is low for 2*beats + g cycles.
- R7: Response beats are taken only in cycles where the port's `rx_vld` bit is high. The response frame holds read data in bits 31:0 and an error flag in bit 32. The cycle after the last response beat, ready is high with `hresp` equal to that flag and `hrdata` equal to the read data.
- R8: In single configuration port B never stalls or responds. Its ready stays high, its `hresp` stays low, its `hrdata` stays zero and `tx_vld[1]` stays low, whatever appears on its bus inputs or on `rx_vld[1]`.
- R9: In dual configuration the two ports run their transfers independently and at the same time, each with the timing of R6.
- R10: A new address phase presented during the completion cycle is taken, so ready is high for exactly one cycle between two back-to-back transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and link |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dual | input | 1 | Link partition, sampled while in reset |
| hsel | input | 2 | Slave select, one bit per port |
| htrans | input | 2x2 | Transfer type per port |
| haddr | input | 2x32 | Address per port |
| hwrite | input | 2 | Write flag per port |
| hsize | input | 2x3 | Transfer size per port |
| hwdata | input | 2x32 | Write data per port, data phase |
| hready | output | 2 | Ready per port, low during wait states |
| hresp | output | 2 | Error response per port, in completion cycle |
| hrdata | output | 2x32 | Read data per port |
| tx_data | output | 20 | Outgoing link beat, two bits per line |
| tx_vld | output | 2 | Outgoing frame marker per port |
| rx_data | input | 20 | Incoming link beat |
| rx_vld | input | 2 | Incoming frame marker per port |

## Verification
Some rules are checked on every clock. An error response must come with ready high. A taken address phase must be followed by a wait state. Ready may only rise after a response beat has arrived. Every outgoing frame must last exactly the beat count of the latched configuration. In single configuration port B must stay quiet, and the latched configuration must not move after reset. Only the scenarios against a peer model can show that the frame fields land on the right lines and come back intact. The same applies to the exact number of wait states for a given response delay, to back-to-back acceptance in the completion cycle, and to two dual-configuration ports completing concurrent transfers correctly.

// File: rtl/ahb_link_ser.sv
module ahb_link_ser #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LINES = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_dual,
  input  logic [1:0]              hsel,
  input  logic [1:0][1:0]         htrans,
  input  logic [1:0][AW-1:0]      haddr,
  input  logic [1:0]              hwrite,
  input  logic [1:0][2:0]         hsize,
  input  logic [1:0][DW-1:0]      hwdata,
  output logic [1:0]              hready,
  output logic [1:0]              hresp,
  output logic [1:0][DW-1:0]      hrdata,
  output logic [2*LINES-1:0]      tx_data,
  output logic [1:0]              tx_vld,
  input  logic [2*LINES-1:0]      rx_data,
  input  logic [1:0]              rx_vld
);

  localparam int WS  = 2 * LINES;
  localparam int WD  = LINES;
  localparam int HB  = AW + DW + 4;
  localparam int FW  = ((HB + WS - 1) / WS) * WS;
  localparam int NBS = FW / WS;
  localparam int NBD = FW / WD;
  localparam int CW  = $clog2(NBD);

  typedef enum logic [2:0] {IDLE, DPH, SEND, RESP, DONE} st_t;

  logic          dual_q;
  logic [CW-1:0] last;

  always_ff @(posedge clk)
    if (!rst_n) dual_q <= cfg_dual;

  assign last = dual_q ? CW'(NBD - 1) : CW'(NBS - 1);

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam bit PA = (p == 0);
    st_t           st;
    logic [CW-1:0] cnt;
    logic [FW-1:0] tsr;
    logic [FW-1:0] rsr;
    logic          en, take, snd;
    logic [WD-1:0] rx_half;

    assign en      = PA || dual_q;
    assign take    = en && hsel[p] && (htrans[p] inside {2'b10, 2'b11}) && hready[p];
    assign rx_half = rx_data[p*WD +: WD];
    assign snd     = (st == SEND);

    assign hready[p] = (st == IDLE) || (st == DONE);
    assign hresp[p]  = (st == DONE) && rsr[DW];
    assign hrdata[p] = rsr[DW-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st  <= IDLE;
        cnt <= '0;
        tsr <= '0;
        rsr <= '0;
      end else begin
        case (st)
          IDLE, DONE: begin
            if (take) begin
              st  <= DPH;
              tsr <= FW'({hsize[p], hwrite[p], {DW{1'b0}}, haddr[p]});
            end else begin
              st <= IDLE;
            end
          end
          DPH: begin
            tsr[AW +: DW] <= hwdata[p];
            cnt           <= '0;
            st            <= SEND;
          end
          SEND: begin
            tsr <= dual_q ? (tsr >> WD) : (tsr >> WS);
            if (cnt == last) begin
              cnt <= '0;
              st  <= RESP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RESP: begin
            if (rx_vld[p]) begin
              rsr <= dual_q ? {rx_half, rsr[FW-1:WD]} : {rx_data, rsr[FW-1:WS]};
              if (cnt == last) begin
                cnt <= '0;
                st  <= DONE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  assign tx_data = dual_q ? {g_port[1].tsr[WD-1:0], g_port[0].tsr[WD-1:0]}
                          : g_port[0].tsr[WS-1:0];
  assign tx_vld  = {g_port[1].snd, g_port[0].snd};

endmodule

// File: rtl/ahb_link_ser_chk.sv
module ahb_link_ser_chk #(
  parameter int NBS = 4,
  parameter int NBD = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dual_q,
  input logic [1:0]      hsel,
  input logic [1:0][1:0] htrans,
  input logic [1:0]      hready,
  input logic [1:0]      hresp,
  input logic [1:0]      tx_vld,
  input logic [1:0]      rx_vld
);

  logic [7:0] run0, run1;
  logic       tk0, tk1;

  assign tk0 = hsel[0] && (htrans[0] inside {2'b10, 2'b11}) && hready[0];
  assign tk1 = dual_q && hsel[1] && (htrans[1] inside {2'b10, 2'b11}) && hready[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run0 <= '0;
      run1 <= '0;
    end else begin
      run0 <= tx_vld[0] ? run0 + 8'd1 : 8'd0;
      run1 <= tx_vld[1] ? run1 + 8'd1 : 8'd0;
    end
  end

  a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(dual_q));

  a_r4_frame_beats: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_vld[0]) |-> run0 == (dual_q ? 8'(NBD) : 8'(NBS)));

  a_r5_frame_beats_b: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_vld[1]) |-> run1 == 8'(NBD));

  a_r6_stall_a: assert property (@(posedge clk) disable iff (!rst_n)
    tk0 |=> !hready[0]);

  a_r6_stall_b: assert property (@(posedge clk) disable iff (!rst_n)
    tk1 |=> !hready[1]);

  a_r7_err_with_ready_a: assert property (@(posedge clk) disable iff (!rst_n)
    hresp[0] |-> hready[0]);

  a_r7_err_with_ready_b: assert property (@(posedge clk) disable iff (!rst_n)
    hresp[1] |-> hready[1]);

  a_r7_done_after_rx_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hready[0]) |-> $past(rx_vld[0]));

  a_r7_done_after_rx_b: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hready[1]) |-> $past(rx_vld[1]));

  a_r8_port_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_q |-> (hready[1] && !hresp[1] && !tx_vld[1]));

endmodule

bind ahb_link_ser ahb_link_ser_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .dual_q (dual_q),
  .hsel   (hsel),
  .htrans (htrans),
  .hready (hready),
  .hresp  (hresp),
  .tx_vld (tx_vld),
  .rx_vld (rx_vld)
);

// File: tb/test_ahb_link_ser.sv
module test_ahb_link_ser;

  typedef struct {
    logic [31:0] rd;
    logic        err;
    bit          chk_rd;
    bit          b2b;
    int          waits;
    string       tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_dual;
  logic [1:0]      hsel;
  logic [1:0][1:0] htrans;
  logic [1:0][31:0] haddr;
  logic [1:0]      hwrite;
  logic [1:0][2:0] hsize;
  logic [1:0][31:0] hwdata;
  wire  [1:0]      hready;
  wire  [1:0]      hresp;
  wire  [1:0][31:0] hrdata;
  wire  [19:0]     tx_data;
  wire  [1:0]      tx_vld;
  logic [19:0]     rx_data;
  logic [1:0]      rx_vld;

  int   nchk = 0, nfail = 0;
  bit   bdual = 0;
  bit   finished = 0;
  int   gapv [2];
  exp_t q0 [$];
  exp_t q1 [$];
  logic [31:0] ref_mem  [logic [31:0]];
  logic [31:0] peer_mem [logic [31:0]];

  always #4 clk = ~clk;

  ahb_link_ser i_ahb_link_ser (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual),
    .hsel(hsel), .htrans(htrans), .haddr(haddr), .hwrite(hwrite),
    .hsize(hsize), .hwdata(hwdata),
    .hready(hready), .hresp(hresp), .hrdata(hrdata),
    .tx_data(tx_data), .tx_vld(tx_vld), .rx_data(rx_data), .rx_vld(rx_vld)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input int p, input logic wr, input logic [31:0] a,
                      input logic [31:0] wd, input logic [2:0] sz, input int gap,
                      input bit b2b, input string tag);
    exp_t e;
    int nb;
    @(negedge clk);
    while (!hready[p]) @(negedge clk);
    nb      = bdual ? 8 : 4;
    gapv[p] = gap;
    hsel[p] = 1'b1; htrans[p] = 2'b10; haddr[p] = a; hwrite[p] = wr; hsize[p] = sz;
    e.err    = a[31];
    e.chk_rd = !wr;
    e.b2b    = b2b;
    e.waits  = 2 * nb + gap;
    e.tag    = tag;
    if (wr) begin
      e.rd = '0;
      if (!a[31]) ref_mem[a] = wd;
    end else begin
      e.rd = (ref_mem.exists(a) ? ref_mem[a] : ~a) ^ {29'd0, sz};
    end
    if (p == 0) q0.push_back(e); else q1.push_back(e);
    @(negedge clk);
    hsel[p] = 1'b0; htrans[p] = 2'b00; hwdata[p] = wd;
  endtask

  task automatic monitor(input int p);
    int lows = 0;
    int highs = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        lows = 0; highs = 0;
      end else if (!hready[p]) begin
        if (lows == 0 && ((p == 0 && q0.size() > 0 && q0[0].b2b) ||
                          (p == 1 && q1.size() > 0 && q1[0].b2b)))
          check(highs == 1, "R10", "ready-high cycles between transfers", 64'(highs), 64'd1);
        lows++;
        highs = 0;
      end else if (lows > 0) begin
        if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
          check(1'b0, "R6", "completion with nothing pending", 64'(p), 64'd0);
        end else begin
          e = (p == 0) ? q0.pop_front() : q1.pop_front();
          check(lows == e.waits, e.tag, "R6 wait cycles", 64'(lows), 64'(e.waits));
          check(hresp[p] == e.err, e.tag, "R7 error flag", 64'(hresp[p]), 64'(e.err));
          if (e.chk_rd)
            check(hrdata[p] == e.rd, e.tag, "R3 R7 read data", 64'(hrdata[p]), 64'(e.rd));
        end
        lows = 0;
        highs = 1;
      end else begin
        highs++;
      end
    end
  endtask

  task automatic peer(input int g);
    logic [79:0] f, r;
    logic [31:0] a, rd;
    logic        e;
    int          k, w;
    k = 0; f = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        k = 0;
      end else if (tx_vld[g]) begin
        w = bdual ? 10 : 20;
        for (int i = 0; i < w; i++) f[k*w+i] = tx_data[g*10+i];
        k++;
        if (k * w >= 80) begin
          k  = 0;
          a  = f[31:0];
          e  = a[31] | (|f[79:68]);
          if (f[64]) begin
            rd = '0;
            if (!e) peer_mem[a] = f[63:32];
          end else begin
            rd = (peer_mem.exists(a) ? peer_mem[a] : ~a) ^ {29'd0, f[67:65]};
          end
          r = {47'd0, e, rd};
          repeat (gapv[g]) @(negedge clk);
          for (int b = 0; b < 80 / w; b++) begin
            rx_vld[g] = 1'b1;
            for (int i = 0; i < w; i++) rx_data[g*10+i] = r[b*w+i];
            @(negedge clk);
          end
          rx_vld[g] = 1'b0;
        end
      end
    end
  endtask

  task automatic drain();
    while (q0.size() > 0 || q1.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_dual = 1'b0;
    hsel = '0; htrans = '0; haddr = '0; hwrite = '0; hsize = '0; hwdata = '0;
    rx_data = '0; rx_vld = '0;
    gapv[0] = 1; gapv[1] = 1;
    fork
      monitor(0); monitor(1); peer(0); peer(1);
    join_none

    repeat (3) @(negedge clk);
    check(hready == 2'b11 && hresp == 2'b00 && tx_vld == 2'b00, "R1", "reset outputs",
          64'({hready, hresp, tx_vld}), 64'(6'b110000));
    rst_n = 1'b1;
    @(negedge clk);
    check(hready == 2'b11 && tx_vld == 2'b00, "R1", "outputs after release",
          64'({hready, tx_vld}), 64'(4'b1100));

    xfer(0, 1'b1, 32'h0000_0100, 32'hCAFE_0001, 3'd2, 1, 1'b0, "R4");
    xfer(0, 1'b0, 32'h0000_0100, 32'h0,          3'd2, 1, 1'b0, "R4");
    xfer(0, 1'b0, 32'h0000_0200, 32'h0,          3'd0, 3, 1'b0, "R3");
    xfer(0, 1'b1, 32'h8000_0040, 32'h1234_5678, 3'd2, 2, 1'b0, "R7");
    xfer(0, 1'b0, 32'h8000_0040, 32'h0,          3'd1, 1, 1'b0, "R7");
    drain();
    xfer(0, 1'b1, 32'h0000_0300, 32'hA5A5_5A5A, 3'd2, 1, 1'b0, "R10");
    xfer(0, 1'b0, 32'h0000_0300, 32'h0,          3'd2, 1, 1'b1, "R10");
    drain();

    // R8: port B stimulus in single configuration
    hsel[1] = 1'b1; htrans[1] = 2'b10; haddr[1] = 32'h0000_0500; hwrite[1] = 1'b0;
    rx_vld[1] = 1'b1; rx_data[19:10] = '1;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      check(hready[1] && !hresp[1] && tx_vld == 2'b00 && hrdata[1] == '0, "R8",
            "port B quiet", 64'({hready[1], hresp[1], tx_vld, hrdata[1]}), 64'({1'b1, 35'd0}));
    end
    hsel[1] = 1'b0; htrans[1] = 2'b00; rx_vld[1] = 1'b0; rx_data = '0;
    @(negedge clk);

    cfg_dual = 1'b1;
    xfer(0, 1'b0, 32'h0000_0100, 32'h0, 3'd3, 2, 1'b0, "R2");
    drain();

    rst_n = 1'b0; bdual = 1;
    repeat (3) @(negedge clk);
    check(hready == 2'b11 && hresp == 2'b00 && tx_vld == 2'b00, "R1", "reset outputs dual",
          64'({hready, hresp, tx_vld}), 64'(6'b110000));
    rst_n = 1'b1;
    cfg_dual = 1'b0;
    @(negedge clk);

    fork
      begin
        xfer(0, 1'b1, 32'h0000_0400, 32'h0BAD_F00D, 3'd2, 1, 1'b0, "R5");
        xfer(0, 1'b0, 32'h0000_0400, 32'h0,          3'd2, 3, 1'b0, "R9");
        xfer(0, 1'b0, 32'h8000_0000, 32'h0,          3'd0, 1, 1'b0, "R7");
      end
      begin
        xfer(1, 1'b1, 32'h0000_0600, 32'h7777_1111, 3'd2, 2, 1'b0, "R5");
        xfer(1, 1'b0, 32'h0000_0600, 32'h0,          3'd1, 1, 1'b1, "R9");
        xfer(1, 1'b0, 32'h0000_0700, 32'h0,          3'd2, 1, 1'b0, "R2");
      end
    join
    drain();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule